// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns characters held in a small transmit queue into asynchronous serial frames on a single output line. A separate baud generator supplies a one-cycle bit-rate tick. Every tick advances the line by one bit period. Software-facing logic outside the block supplies a character write strobe, a level mode word and a one-cycle control command.

The mode word selects the frame shape at run time: 6, 7 or 8 data bits, one of five parity options (even, odd, forced zero, forced one, or no parity bit) and one or two stop bits. The control command turns the transmitter on or off, resets its logic, and raises or lowers a break condition. A break holds the line low for as long as it lasts. The queue reports empty and full so that a producer can pace its writes.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is high, `fifo_empty` is 1, `fifo_full` is 0, the transmitter is disabled and no break is active.
- R2: Mode bits [2:1] set the character length: 00 gives 8 data bits, 10 gives 7 and 11 gives 6. Data bits above the length are not sent.
- R3: Mode bits [5:3] set the parity bit that follows the data. 000 makes the count of ones in data plus parity even. 001 makes it odd. 010 sends 0, 011 sends 1, and 1xx sends no parity bit.
- R4: Mode bits [7:6] set the stop bits: 00 sends one high stop bit and 10 sends two.
- R5: A frame is one low start bit, then the data least significant bit first, then parity and stop bits. Each bit lasts from one `baud_tick` to the next, and the line idles high.
- R6: Control bit 4 enables the transmitter and control bit 5 disables it. On disable, a frame in progress completes, no further character is taken and the queue keeps its contents. A later enable resumes transmission.
- R7: If control bits 4 and 5 are set in the same command, the transmitter ends up disabled.
- R8: Control bit 1 empties the queue and abandons any frame in progress. The line is high in the cycle after the command unless a break is active. The enable state is kept.
- R9: The queue holds 16 characters. `fifo_full` is 1 at 16 entries and `fifo_empty` is 1 at zero entries. A write while full is dropped and leaves the stored characters intact.
- R10: Control bit 7 starts a break, which drives the line low from the next cycle. While the break lasts, no new frame starts. Control bit 8 ends the break, and bit 8 wins if both bits are set.
- R11: The mode word is sampled when a frame starts. Changing it mid-frame does not alter that frame.
- R12: When a character is waiting and the transmitter is enabled, the next start bit follows the last stop bit with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-period strobe from the baud generator |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Character to enqueue |
| mode | input | 8 | Frame format word (length, parity, stop fields) |
| ctrl_wr | input | 1 | One-cycle control command strobe |
| ctrl | input | 9 | Control command bits (reset, enable, disable, break on, break off) |
| tx_line | output | 1 | Serial output, idle high |
| fifo_empty | output | 1 | Transmit queue holds no characters |
| fifo_full | output | 1 | Transmit queue holds 16 characters |

## Verification
The hardest case to reach from the ports is a command that arrives while a frame is on the wire. A disable must let the frame finish but hold the next character back. A transmit reset must cut the frame short. A mode change must leave the current frame alone. The stimulus waits at the falling clock edge until the line first goes low, which marks the start bit, and issues the command at that point. The bench also fills the queue with the transmitter disabled, so a seventeenth write hits a full queue. It then enables transmission and checks that exactly the first sixteen characters come out.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Longest frame: start + 8 data + parity + 2 stop
  localparam int FRAME_MAX = 12;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  // Control command bit positions
  localparam int CMD_RST     = 1;
  localparam int CMD_ENABLE  = 4;
  localparam int CMD_DISABLE = 5;
  localparam int CMD_BRK_ON  = 7;
  localparam int CMD_BRK_OFF = 8;

  typedef logic [FRAME_MAX-1:0] frame_t;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'b00,
    PAR_ODD   = 2'b01,
    PAR_ZERO  = 2'b10,
    PAR_ONE   = 2'b11
  } par_kind_t;

  function automatic int data_width(input logic [7:0] m);
    case (m[2:1])
      2'b10:   return 7;
      2'b11:   return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic parity_on(input logic [7:0] m);
    return !m[5];
  endfunction

  function automatic int stop_width(input logic [7:0] m);
    return m[7] ? 2 : 1;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [7:0] m);
    int total;
    total = 1 + data_width(m) + (parity_on(m) ? 1 : 0) + stop_width(m);
    return LEN_W'(total);
  endfunction

  // Builds the frame LSB-first; unused upper bits stay high (stop/idle)
  function automatic frame_t build_frame(input logic [7:0] m, input logic [7:0] d);
    frame_t     f;
    logic [7:0] kept;
    logic       pbit;
    int         n;
    par_kind_t  kind;
    n    = data_width(m);
    f    = '1;
    kept = '0;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        kept[i]  = d[i];
        f[1 + i] = d[i];
      end
    end
    kind = par_kind_t'(m[4:3]);
    case (kind)
      PAR_EVEN: pbit = ^kept;
      PAR_ODD:  pbit = ~^kept;
      PAR_ZERO: pbit = 1'b0;
      default:  pbit = 1'b1;
    endcase
    if (parity_on(m)) f[1 + n] = pbit;
    return f;
  endfunction

endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wr_ptr)));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/tx_cmd.sv
module tx_cmd
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [8:0] cmd,
  output logic       tx_on,
  output logic       brk_on,
  output logic       soft_rst
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd[0], cmd[3:2], cmd[6]};

  assign soft_rst = cmd_wr && cmd[CMD_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on  <= 1'b0;
      brk_on <= 1'b0;
    end else if (cmd_wr) begin
      if (cmd[CMD_DISABLE])      tx_on <= 1'b0;
      else if (cmd[CMD_ENABLE])  tx_on <= 1'b1;
      if (cmd[CMD_BRK_OFF])      brk_on <= 1'b0;
      else if (cmd[CMD_BRK_ON])  brk_on <= 1'b1;
    end
  end

  // R7
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd[CMD_DISABLE]) |=> !tx_on);

  // R10
  brk_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd[CMD_BRK_OFF]) |=> !brk_on);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       baud_tick,
  input  logic       may_start,
  input  logic [7:0] fmt,
  input  logic [7:0] char_in,
  output logic       take,
  output logic       bit_out,
  output logic       busy
);
  frame_t           shreg;
  logic [LEN_W-1:0] bits_left;
  logic             last_bit;
  logic             start_evt;

  assign last_bit  = busy && (bits_left == LEN_W'(1));
  assign start_evt = baud_tick && (!busy || last_bit) && may_start && !abort;
  assign take      = start_evt;
  assign bit_out   = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      busy      <= 1'b0;
    end else if (abort) begin
      shreg     <= '1;
      bits_left <= '0;
      busy      <= 1'b0;
    end else if (baud_tick) begin
      if (start_evt) begin
        shreg     <= build_frame(fmt, char_in);
        bits_left <= frame_len(fmt);
        busy      <= 1'b1;
      end else if (last_bit) begin
        busy      <= 1'b0;
        bits_left <= '0;
        shreg     <= '1;
      end else if (busy) begin
        shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && !bit_out));

  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !abort) |=> ($stable(bit_out) && $stable(busy)));

  // R12
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && baud_tick && may_start && !abort) |=> busy);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int QDEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] mode,
  input  logic       ctrl_wr,
  input  logic [8:0] ctrl,
  output logic       tx_line,
  output logic       fifo_empty,
  output logic       fifo_full
);
  logic       tx_on, brk_on, soft_rst;
  logic       take, ser_bit, ser_busy;
  logic [7:0] head;
  logic       may_start;

  tx_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (ctrl_wr),
    .cmd      (ctrl),
    .tx_on    (tx_on),
    .brk_on   (brk_on),
    .soft_rst (soft_rst)
  );

  tx_queue #(.DEPTH(QDEPTH), .W(8)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (soft_rst),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (take),
    .head      (head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  assign may_start = tx_on && !brk_on && !fifo_empty;

  tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (soft_rst),
    .baud_tick (baud_tick),
    .may_start (may_start),
    .fmt       (mode),
    .char_in   (head),
    .take      (take),
    .bit_out   (ser_bit),
    .busy      (ser_busy)
  );

  assign tx_line = brk_on ? 1'b0 : ser_bit;

  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl[CMD_BRK_ON] && !ctrl[CMD_BRK_OFF]) |=> !tx_line);

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl[CMD_RST] && !ctrl[CMD_BRK_ON] && !brk_on) |=> (tx_line && fifo_empty));

  // R6
  no_take_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> !take);

endmodule

// File: tb/tb_uart_tx_framer.sv
`timescale 1ns/1ps
module tb_uart_tx_framer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       baud_tick = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] mode = 0;
  logic       ctrl_wr = 0;
  logic [8:0] ctrl = 0;
  logic       tx_line, fifo_empty, fifo_full;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int tick_cnt = 0;
  bit cap[$];
  bit expq[$];

  localparam logic [8:0] C_RST = 9'h002, C_EN = 9'h010, C_DIS = 9'h020,
                         C_BON = 9'h080, C_BOFF = 9'h100;

  always #2 clk = ~clk;  // 250 MHz

  uart_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .mode(mode), .ctrl_wr(ctrl_wr), .ctrl(ctrl),
    .tx_line(tx_line), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  // Capture line once per bit period, then advance the tick generator
  always @(negedge clk) begin
    if (baud_tick) cap.push_back(tx_line);
    tick_cnt  = (tick_cnt + 1) % 4;
    baud_tick <= (tick_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input int got, input int want);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic cmd(input logic [8:0] c);
    @(negedge clk); ctrl_wr = 1; ctrl = c;
    @(negedge clk); ctrl_wr = 0; ctrl = 0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic drain();
    while (!fifo_empty) @(negedge clk);
    ticks(20);
  endtask

  // Expected frame computed by counting bits
  task automatic add_frame(input logic [7:0] m, input logic [7:0] d);
    int n, ones;
    bit pb;
    n = (m[2:1] == 2'b11) ? 6 : (m[2:1] == 2'b10) ? 7 : 8;
    ones = 0;
    expq.push_back(0);
    for (int i = 0; i < n; i++) begin
      expq.push_back(d[i]);
      ones += d[i];
    end
    if (!m[5]) begin
      case (m[4:3])
        2'b00: pb = (ones % 2) == 1;
        2'b01: pb = (ones % 2) == 0;
        2'b10: pb = 0;
        default: pb = 1;
      endcase
      expq.push_back(pb);
    end
    expq.push_back(1);
    if (m[7]) expq.push_back(1);
  endtask

  task automatic check_stream(input string req);
    int k, bad, gotb, wantb;
    k = 0; bad = -1; gotb = 0; wantb = 0;
    while (k < cap.size() && cap[k] == 1) k++;
    for (int j = 0; j < expq.size(); j++) begin
      if (k + j >= cap.size()) begin bad = j; gotb = -1; wantb = expq[j]; break; end
      if (cap[k + j] != expq[j]) begin bad = j; gotb = cap[k + j]; wantb = expq[j]; break; end
    end
    if (bad < 0) begin
      for (int j = k + expq.size(); j < cap.size(); j++) begin
        if (cap[j] != 1) begin bad = j - k; gotb = 0; wantb = 1; break; end
      end
    end
    tests++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: bit %0d of stream got %0d expected %0d", req, bad, gotb, wantb);
    end
  endtask

  task automatic begin_stream();
    cap.delete();
    expq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5];
    logic [7:0] m;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h3C; pats[4] = 8'h96;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(tx_line == 1, "R1 line", tx_line, 1);
    chk(fifo_empty == 1, "R1 empty", fifo_empty, 1);
    chk(fifo_full == 0, "R1 full", fifo_full, 0);
    put(8'h55);
    ticks(15);
    chk(tx_line == 1 && fifo_empty == 0, "R1 disabled after reset", tx_line, 1);
    cmd(C_RST);

    // R2 R3 R4 R5 R12: sweep every format, five chars back to back
    cmd(C_EN);
    for (int l = 0; l < 3; l++) begin
      for (int p = 0; p < 5; p++) begin
        for (int s = 0; s < 2; s++) begin
          m = 8'h00;
          m[2:1] = (l == 0) ? 2'b00 : (l == 1) ? 2'b10 : 2'b11;
          m[5:3] = (p == 4) ? 3'b100 : 3'(p);
          m[7:6] = s ? 2'b10 : 2'b00;
          mode = m;
          begin_stream();
          for (int i = 0; i < 5; i++) begin
            put(pats[i] ^ 8'(l * 16 + p * 4 + s));
            add_frame(m, pats[i] ^ 8'(l * 16 + p * 4 + s));
          end
          drain();
          check_stream($sformatf("R2 R3 R4 R5 R12 mode=%02h", m));
        end
      end
    end

    // R11: mode changed mid-frame does not alter it
    mode = 8'h20;
    begin_stream();
    put(8'hC3);
    add_frame(8'h20, 8'hC3);
    while (tx_line) @(negedge clk);
    mode = 8'hC6;
    drain();
    check_stream("R11 mode sampled at start");
    mode = 8'h20;

    // R6: disable mid-frame, current completes, next held
    begin_stream();
    put(8'h81);
    put(8'h42);
    add_frame(8'h20, 8'h81);
    while (tx_line) @(negedge clk);
    cmd(C_DIS);
    ticks(30);
    check_stream("R6 frame finishes after disable");
    chk(fifo_empty == 0, "R6 queue kept", fifo_empty, 0);
    begin_stream();
    add_frame(8'h20, 8'h42);
    cmd(C_EN);
    drain();
    check_stream("R6 resume on enable");

    // R7: both enable and disable -> disabled
    cmd(C_EN | C_DIS);
    begin_stream();
    put(8'h11);
    ticks(30);
    check_stream("R7 disable wins");
    chk(fifo_empty == 0, "R7 char held", fifo_empty, 0);

    // R8: reset flushes queue, enable kept
    put(8'h22);
    put(8'h33);
    cmd(C_RST);
    chk(fifo_empty == 1, "R8 flush", fifo_empty, 1);
    cmd(C_EN);
    begin_stream();
    ticks(30);
    check_stream("R8 nothing sent after flush");
    put(8'h0F);
    while (tx_line) @(negedge clk);
    cmd(C_RST);
    chk(tx_line == 1, "R8 abort mid-frame", tx_line, 1);
    begin_stream();
    ticks(20);
    check_stream("R8 stays idle after abort");
    begin_stream();
    put(8'h5A);
    add_frame(8'h20, 8'h5A);
    drain();
    check_stream("R8 enable kept");

    // R9: fill, overflow write dropped
    cmd(C_DIS);
    begin_stream();
    for (int i = 0; i < 16; i++) begin
      chk(fifo_full == 0, "R9 not full early", fifo_full, 0);
      put(8'(i * 7 + 1));
      add_frame(8'h20, 8'(i * 7 + 1));
    end
    chk(fifo_full == 1, "R9 full at 16", fifo_full, 1);
    put(8'hEE);
    chk(fifo_full == 1, "R9 still full", fifo_full, 1);
    cmd(C_EN);
    drain();
    check_stream("R9 overflow dropped, 16 kept");
    chk(fifo_empty == 1 && fifo_full == 0, "R9 empty after drain", fifo_empty, 1);

    // R10: break holds line low and blocks frames
    cmd(C_BON);
    chk(tx_line == 0, "R10 break low", tx_line, 0);
    put(8'h99);
    ticks(25);
    chk(tx_line == 0, "R10 still low", tx_line, 0);
    chk(fifo_empty == 0, "R10 no start in break", fifo_empty, 0);
    cmd(C_BON | C_BOFF);
    begin_stream();
    add_frame(8'h20, 8'h99);
    chk(tx_line == 1, "R10 stop wins", tx_line, 1);
    drain();
    check_stream("R10 frame after break");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule